// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer Counter

This block is a 16-bit counter that advances on a clock-enable tick after an internal prescaler has divided that tick by 1, 8, 32 or 128. A two-bit mode field either stops the counter or runs it in one of three patterns. Free-running counts up and wraps. Modulo counts up to a programmable period and returns to zero. Up/down climbs to the period and descends back to zero.

Software reaches the block through a small 8-bit register port. The count is read as two bytes. Reading the low byte captures the high byte in a holding register, so the pair read low-then-high is one consistent value. Any write to the low count byte clears the counter. A terminal event sets a sticky overflow flag, and that flag drives an interrupt line while the interrupt enable is set.

Register map (3-bit address): 0 count low byte (read: low byte and capture of high byte; write: clear counter); 1 captured high byte (read only); 2 control, bits [1:0] mode (0 stop, 1 free-running, 2 modulo, 3 up/down), bits [3:2] prescale select (0 → ÷1, 1 → ÷8, 2 → ÷32, 3 → ÷128), bit 4 interrupt enable; 3 status, bit 0 overflow flag; 4 period low byte; 5 period high byte.

Top module: `tick_timer16`

## Requirements
- R1: After reset the count reads 0x0000, control and status read 0x00, both period bytes read 0xFF, and irq is low.
- R2: With prescale select 0, 1, 2 or 3 the count advances once per 1, 8, 32 or 128 ticks. After a start from halt or after a clear, the first advance needs the full number of ticks.
- R3: Mode 0 freezes the count at its present value whatever ticks arrive. A later non-zero mode resumes counting from that value.
- R4: In free-running mode (1) the count goes up by one per advance and wraps from 0xFFFF to 0x0000. The overflow flag is set on the advance that makes the count 0xFFFF.
- R5: In modulo mode (2) the count goes up to the period and the next advance gives 0x0000. The flag is set on the advance that makes the count equal the period.
- R6: In modulo mode a count already above the period keeps rising to 0xFFFF, wraps to 0x0000 and then follows the period.
- R7: In up/down mode (3) the count rises from 0 to the period, then falls to 0 and rises again. The flag is set on the advance that brings the count down to 0.
- R8: Reading address 0 returns the low byte and captures the high byte. Address 1 returns the captured byte even if the counter has moved since.
- R9: Any write to address 0 clears the count to 0x0000, whatever the data.
- R10: The overflow flag stays set until a status write with bit 0 at 0. A write with bit 0 at 1 leaves it alone. A flag set in the same cycle as a clearing write wins.
- R11: irq is high exactly while the flag and the interrupt enable (control bit 4) are both set.
- R12: The count never changes on a cycle where tick_en is low, except through a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Clock-enable tick feeding the prescaler |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (captures high byte on address 0) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach are those around the 0xFFFF boundary: the free-running wrap and the modulo case where the count starts above the period. The only way to load the counter is to clear it. The bench therefore holds tick_en high at a ÷1 prescale for about 65 thousand cycles to climb there. For the modulo-above-period case it first free-runs past a small period and then switches mode without clearing. The collision between a hardware flag set and a software flag clear is produced by aligning a status write with the tick that reaches the modulo period.

// File: rtl/tmr_pkg.sv
// Shared constants and types for the multi-mode timer.
// Assumes the count is exactly two register bytes wide.
package tmr_pkg;

    localparam int CNT_W  = 16;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int DIV_W  = 2;
    localparam int PS_W   = 7;

    typedef enum logic [1:0] {
        MODE_STOP   = 2'd0,
        MODE_FREE   = 2'd1,
        MODE_MODULO = 2'd2,
        MODE_UPDOWN = 2'd3
    } tmr_mode_e;

    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd3;
    localparam logic [ADDR_W-1:0] A_PER_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_PER_HI = 3'd5;

    // Last prescaler count before an advance, per select value.
    function automatic logic [PS_W-1:0] div_last(input logic [DIV_W-1:0] sel);
        logic [PS_W:0] full;
        case (sel)
            2'd0:    full = (PS_W+1)'(1);
            2'd1:    full = (PS_W+1)'(8);
            2'd2:    full = (PS_W+1)'(32);
            default: full = (PS_W+1)'(128);
        endcase
        return PS_W'(full - 1'b1);
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
// Tick prescaler: counts incoming ticks and emits one advance pulse per
// 1, 8, 32 or 128 ticks. Assumes it is held at zero while stopped or cleared,
// so a start always begins a full division period.
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int P_DIV_W = DIV_W,
    parameter int P_PS_W  = PS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               clr,
    input  logic               tick_en,
    input  logic [P_DIV_W-1:0] div_sel,
    output logic               adv
);

    logic [P_PS_W-1:0] pcnt_q;
    logic [P_PS_W-1:0] last;
    logic              at_last;

    // Terminal count for the selected division.
    always_comb begin
        last    = P_PS_W'(div_last(DIV_W'(div_sel)));
        at_last = (pcnt_q == last);
        adv     = run && !clr && tick_en && at_last;
    end

    // Division counter, held in reset while halted or cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || clr) begin
            pcnt_q <= '0;
        end else if (tick_en) begin
            pcnt_q <= at_last ? '0 : pcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_counter.sv
// Main counter: applies the selected mode on each advance pulse and reports
// a one-cycle terminal event. Assumes clr has priority over advancing.
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int P_CNT_W = CNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               adv,
    input  tmr_mode_e          mode,
    input  logic [P_CNT_W-1:0] period,
    output logic [P_CNT_W-1:0] cnt,
    output logic               term
);

    localparam logic [P_CNT_W-1:0] CNT_MAX = '1;
    localparam logic [P_CNT_W-1:0] CNT_ONE = P_CNT_W'(1);

    logic [P_CNT_W-1:0] cnt_q;
    logic [P_CNT_W-1:0] nxt;
    logic               down_q;
    logic               down_n;
    logic               hit;
    logic               turn;

    // Next count, direction and terminal condition for the current mode.
    always_comb begin
        nxt    = cnt_q;
        down_n = 1'b0;
        hit    = 1'b0;
        turn   = !down_q && (cnt_q >= period);
        case (mode)
            MODE_FREE: begin
                nxt = cnt_q + 1'b1;
                hit = (cnt_q == CNT_MAX - 1'b1);
            end
            MODE_MODULO: begin
                nxt = (cnt_q == period) ? '0 : cnt_q + 1'b1;
                hit = (nxt == period);
            end
            MODE_UPDOWN: begin
                if (turn && cnt_q == '0) begin
                    nxt = '0;
                    hit = 1'b1;
                end else if (down_q || turn) begin
                    nxt    = cnt_q - 1'b1;
                    hit    = (cnt_q == CNT_ONE);
                    down_n = (cnt_q != CNT_ONE);
                end else begin
                    nxt = cnt_q + 1'b1;
                end
            end
            default: begin
                nxt = cnt_q;
            end
        endcase
    end

    // Count and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
        end else if (mode != MODE_UPDOWN && mode != MODE_STOP) begin
            down_q <= 1'b0;
            if (adv) cnt_q <= nxt;
        end else if (adv && mode == MODE_UPDOWN) begin
            cnt_q  <= nxt;
            down_q <= down_n;
        end
    end

    // Terminal event pulse for the flag logic.
    always_comb begin
        cnt  = cnt_q;
        term = adv && !clr && (mode != MODE_STOP) && hit;
    end

endmodule

// File: rtl/tmr_regs.sv
// Register port: control, period, sticky overflow flag, high-byte capture,
// counter clear and read-data mux. Assumes one access per cycle.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int P_CNT_W  = CNT_W,
    parameter int P_DATA_W = DATA_W,
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_DIV_W  = DIV_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [P_ADDR_W-1:0] reg_addr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [P_DATA_W-1:0] reg_wdata,
    output logic [P_DATA_W-1:0] reg_rdata,
    input  logic [P_CNT_W-1:0]  cnt,
    input  logic                term,
    output tmr_mode_e           mode,
    output logic [P_DIV_W-1:0]  div_sel,
    output logic                irq_en,
    output logic [P_CNT_W-1:0]  period,
    output logic                flag,
    output logic [P_DATA_W-1:0] hi_buf,
    output logic                cnt_clr
);

    localparam int CTRL_USED = 2 + P_DIV_W + 1;

    logic wr_cnt_lo, wr_ctrl, wr_stat, wr_per_lo, wr_per_hi, rd_cnt_lo;

    // Address decode of the strobes.
    always_comb begin
        wr_cnt_lo = reg_wr && (reg_addr == P_ADDR_W'(A_CNT_LO));
        wr_ctrl   = reg_wr && (reg_addr == P_ADDR_W'(A_CTRL));
        wr_stat   = reg_wr && (reg_addr == P_ADDR_W'(A_STAT));
        wr_per_lo = reg_wr && (reg_addr == P_ADDR_W'(A_PER_LO));
        wr_per_hi = reg_wr && (reg_addr == P_ADDR_W'(A_PER_HI));
        rd_cnt_lo = reg_rd && (reg_addr == P_ADDR_W'(A_CNT_LO));
        cnt_clr   = wr_cnt_lo;
    end

    // Control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= MODE_STOP;
            div_sel <= '0;
            irq_en  <= 1'b0;
        end else if (wr_ctrl) begin
            mode    <= tmr_mode_e'(reg_wdata[1:0]);
            div_sel <= reg_wdata[2 +: P_DIV_W];
            irq_en  <= reg_wdata[2 + P_DIV_W];
        end
    end

    // Period bytes, reset to the full range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= '1;
        end else begin
            if (wr_per_lo) period[P_DATA_W-1:0]        <= reg_wdata;
            if (wr_per_hi) period[P_CNT_W-1:P_DATA_W]  <= reg_wdata;
        end
    end

    // Sticky overflow flag; a hardware set beats a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (term) begin
            flag <= 1'b1;
        end else if (wr_stat && !reg_wdata[0]) begin
            flag <= 1'b0;
        end
    end

    // High-byte capture on a low-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_buf <= '0;
        end else if (rd_cnt_lo) begin
            hi_buf <= cnt[P_CNT_W-1:P_DATA_W];
        end
    end

    // Read-data mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            P_ADDR_W'(A_CNT_LO): reg_rdata = cnt[P_DATA_W-1:0];
            P_ADDR_W'(A_CNT_HI): reg_rdata = hi_buf;
            P_ADDR_W'(A_CTRL):   reg_rdata = P_DATA_W'({irq_en, div_sel, mode});
            P_ADDR_W'(A_STAT):   reg_rdata = P_DATA_W'(flag);
            P_ADDR_W'(A_PER_LO): reg_rdata = period[P_DATA_W-1:0];
            P_ADDR_W'(A_PER_HI): reg_rdata = period[P_CNT_W-1:P_DATA_W];
            default:             reg_rdata = '0;
        endcase
    end

    // Control bits above the used field are read as zero.
    if (CTRL_USED > P_DATA_W) begin : g_ctrl_width_bad
        initial $display("tmr_regs: control field wider than data port");
    end

endmodule

// File: rtl/tick_timer16.sv
// Multi-mode 16-bit timer top: prescaler, counter and register port.
// Assumes tick_en is synchronous to clk and at most one register access per cycle.
module tick_timer16
    import tmr_pkg::*;
#(
    parameter int P_CNT_W  = CNT_W,
    parameter int P_DATA_W = DATA_W,
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_DIV_W  = DIV_W,
    parameter int P_PS_W   = PS_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic [P_ADDR_W-1:0] reg_addr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [P_DATA_W-1:0] reg_wdata,
    output logic [P_DATA_W-1:0] reg_rdata,
    output logic                irq
);

    tmr_mode_e           mode_w;
    logic [P_DIV_W-1:0]  div_w;
    logic                ie_w;
    logic [P_CNT_W-1:0]  period_w;
    logic [P_CNT_W-1:0]  cnt_w;
    logic                flag_w;
    logic [P_DATA_W-1:0] hibuf_w;
    logic                clr_w;
    logic                adv_w;
    logic                term_w;
    logic                run_w;

    // Run whenever the mode is non-zero.
    always_comb run_w = (mode_w != MODE_STOP);

    tmr_prescaler #(.P_DIV_W(P_DIV_W), .P_PS_W(P_PS_W)) u_ps (
        .clk(clk), .rst_n(rst_n), .run(run_w), .clr(clr_w),
        .tick_en(tick_en), .div_sel(div_w), .adv(adv_w)
    );

    tmr_counter #(.P_CNT_W(P_CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr_w), .adv(adv_w),
        .mode(mode_w), .period(period_w), .cnt(cnt_w), .term(term_w)
    );

    tmr_regs #(.P_CNT_W(P_CNT_W), .P_DATA_W(P_DATA_W),
               .P_ADDR_W(P_ADDR_W), .P_DIV_W(P_DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cnt(cnt_w), .term(term_w), .mode(mode_w), .div_sel(div_w),
        .irq_en(ie_w), .period(period_w), .flag(flag_w), .hi_buf(hibuf_w),
        .cnt_clr(clr_w)
    );

    // Interrupt request from the sticky flag.
    always_comb irq = flag_w && ie_w;

endmodule

// File: rtl/tmr_checker.sv
// Temporal checks for tick_timer16, attached with bind.
module tmr_checker
    import tmr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        tick_en,
    input logic [2:0]  reg_addr,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [7:0]  reg_wdata,
    input logic [1:0]  mode,
    input logic        adv,
    input logic        clr,
    input logic [15:0] cnt,
    input logic [15:0] period,
    input logic        flag,
    input logic [7:0]  hi_buf
);

    AST_ADV_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> tick_en); // R2
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STOP && !clr) |=> $stable(cnt)); // R3
    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FREE && adv && !clr && cnt == 16'hFFFF) |=> cnt == 16'h0000); // R4
    AST_MODULO_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_MODULO && adv && !clr && cnt == period) |=> cnt == 16'h0000); // R5
    AST_HIGH_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_CNT_LO) |=> hi_buf == $past(cnt[15:8])); // R8
    AST_LOW_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CNT_LO) |=> cnt == 16'h0000); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(reg_wr && reg_addr == A_STAT && !reg_wdata[0])) |=> flag); // R10
    AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !clr) |=> $stable(cnt)); // R12

endmodule

bind tick_timer16 tmr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .mode(mode_w), .adv(adv_w), .clr(clr_w), .cnt(cnt_w),
    .period(period_w), .flag(flag_w), .hi_buf(hibuf_w)
);

// File: tb/tb_tick_timer16.sv
module tb_tick_timer16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;

    tick_timer16 dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic rd_count(output int v);
        logic [7:0] lo, hi;
        rd(3'd0, lo);
        rd(3'd1, hi);
        v = {hi, lo};
    endtask

    task automatic rd_flag(output int v);
        logic [7:0] s;
        rd(3'd3, s);
        v = s[0];
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            tick_en = 1'b1;
            repeat (n) @(posedge clk);
            #1 tick_en = 1'b0;
        end
    endtask

    // ctrl byte: {ie, div[1:0], mode[1:0]}
    task automatic setup(input int mode, input int div, input int ie, input int per);
        wr(3'd2, 8'h00);
        wr(3'd0, 8'h00);
        wr(3'd3, 8'h00);
        wr(3'd4, per[7:0]);
        wr(3'd5, per[15:8]);
        wr(3'd2, 8'((ie << 4) | (div << 2) | mode));
    endtask

    task automatic t_reset();
        logic [7:0] d;
        int v;
        rd_count(v); check("R1 count", v, 0);
        rd(3'd2, d); check("R1 ctrl", d, 0);
        rd(3'd3, d); check("R1 stat", d, 0);
        rd(3'd4, d); check("R1 period lo", d, 8'hFF);
        rd(3'd5, d); check("R1 period hi", d, 8'hFF);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_prescale();
        int v;
        for (int s = 0; s < 4; s++) begin
            int len;
            len = (s == 0) ? 1 : (s == 1) ? 8 : (s == 2) ? 32 : 128;
            setup(1, s, 0, 16'hFFFF);
            ticks(len - 1); rd_count(v); check("R2 before first advance", v, 0);
            ticks(1);       rd_count(v); check("R2 first advance", v, 1);
            ticks(len);     rd_count(v); check("R2 second advance", v, 2);
        end
    endtask

    task automatic t_stop();
        int v;
        setup(1, 0, 0, 16'hFFFF);
        ticks(5);
        wr(3'd2, 8'h00);
        ticks(20); rd_count(v); check("R3 frozen", v, 5);
        wr(3'd2, 8'h01);
        ticks(1); rd_count(v); check("R3 resumes", v, 6);
    endtask

    task automatic t_tick_gate();
        int v;
        setup(1, 0, 0, 16'hFFFF);
        ticks(3);
        repeat (10) @(posedge clk);
        #1 rd_count(v); check("R12 no tick no move", v, 3);
    endtask

    task automatic t_free();
        int v, f;
        setup(1, 0, 0, 16'hFFFF);
        ticks(65534); rd_count(v); check("R4 at FFFE", v, 16'hFFFE);
        rd_flag(f); check("R4 flag before", f, 0);
        ticks(1); rd_count(v); check("R4 at FFFF", v, 16'hFFFF);
        rd_flag(f); check("R4 flag at FFFF", f, 1);
        ticks(1); rd_count(v); check("R4 wrap", v, 0);
    endtask

    task automatic t_modulo();
        int v, f;
        setup(2, 0, 0, 4);
        ticks(3); rd_count(v); check("R5 count 3", v, 3);
        rd_flag(f); check("R5 flag before", f, 0);
        ticks(1); rd_count(v); check("R5 at period", v, 4);
        rd_flag(f); check("R5 flag at period", f, 1);
        ticks(1); rd_count(v); check("R5 return", v, 0);
        ticks(1); rd_count(v); check("R5 restart", v, 1);
    endtask

    task automatic t_modulo_above();
        int v, f;
        setup(1, 0, 0, 5);
        ticks(10);
        wr(3'd2, 8'h02);
        ticks(65525); rd_count(v); check("R6 climbs to FFFF", v, 16'hFFFF);
        rd_flag(f); check("R6 no flag above period", f, 0);
        ticks(1); rd_count(v); check("R6 wrap", v, 0);
        ticks(5); rd_count(v); check("R6 at period", v, 5);
        ticks(1); rd_count(v); check("R6 follows period", v, 0);
    endtask

    task automatic t_updown();
        int v, f;
        setup(3, 0, 0, 2);
        ticks(2); rd_count(v); check("R7 top", v, 2);
        ticks(1); rd_count(v); check("R7 falling", v, 1);
        rd_flag(f); check("R7 flag before zero", f, 0);
        ticks(1); rd_count(v); check("R7 zero", v, 0);
        rd_flag(f); check("R7 flag at zero", f, 1);
        ticks(1); rd_count(v); check("R7 rising again", v, 1);
    endtask

    task automatic t_latch();
        logic [7:0] lo, hi;
        setup(1, 0, 0, 16'hFFFF);
        ticks(16'h01FE);
        rd(3'd0, lo); check("R8 low byte", lo, 8'hFE);
        ticks(5);
        rd(3'd1, hi); check("R8 captured high", hi, 8'h01);
        rd(3'd0, lo); check("R8 new low", lo, 8'h03);
        rd(3'd1, hi); check("R8 new high", hi, 8'h02);
    endtask

    task automatic t_clear();
        int v;
        setup(1, 0, 0, 16'hFFFF);
        ticks(300);
        wr(3'd0, 8'hA5);
        rd_count(v); check("R9 cleared", v, 0);
    endtask

    task automatic t_flag();
        int v, f;
        setup(2, 0, 0, 1);
        ticks(1); rd_flag(f); check("R10 set", f, 1);
        wr(3'd3, 8'h01); rd_flag(f); check("R10 write one keeps", f, 1);
        wr(3'd3, 8'h00); rd_flag(f); check("R10 write zero clears", f, 0);
        setup(2, 0, 0, 3);
        ticks(2);
        reg_addr = 3'd3; reg_wdata = 8'h00; reg_wr = 1'b1; tick_en = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0; tick_en = 1'b0;
        rd_flag(f); check("R10 set wins over clear", f, 1);
        rd_count(v); check("R10 count at period", v, 3);
    endtask

    task automatic t_irq();
        setup(2, 0, 0, 1);
        ticks(1);
        #1 check("R11 irq masked", irq, 0);
        wr(3'd2, 8'h12);
        check("R11 irq enabled", irq, 1);
        wr(3'd3, 8'h00);
        check("R11 irq after clear", irq, 0);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_prescale();
        t_stop();
        t_tick_gate();
        t_modulo();
        t_updown();
        t_latch();
        t_clear();
        t_flag();
        t_irq();
        t_free();
        t_modulo_above();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule